// File: doc/BRIEF.md
# Conditional Branch and Call Sequencer

This block sequences the program counter of a DSP with 24-bit instructions. Each time the fetch strobe is high, the instruction presented at the input is taken as the one at the current address. The counter then moves to the following address, to a branch target, to a value taken from the serial-output register, or to an address popped from a small return stack. Flag generation and the arithmetic datapath sit outside the block. Both accumulators' flags, the low nibble of the data pointer and the serial handshake bits arrive as plain inputs that are sampled in the execute cycle.

The instruction class is held in bits 23:22. For jump-class words, bits 21:13 hold a 9-bit branch code, bits 12:2 an 11-bit next address and bits 1:0 a bank number. A branch target is built from bit 13 of the incremented counter, the bank in bits 12:11 and the next address in bits 10:0. Long jumps and calls overwrite bit 13 of that target. Calls push the incremented counter onto a four-entry stack whose pointer wraps. A return-class word pops that stack.

Top module: `branch_sequencer`

## Requirements
- R1: While `rst` is high, `pc` and `sp` are 0 after the next rising clock edge, and all stack entries read as 0.
- R2: A cycle with `step` low leaves `pc`, `sp` and the stack unchanged.
- R3: When `step` is high and `instr[23:22]` is 0 or 3, `pc` becomes `pc+1` modulo 2^14 and `sp` is unchanged.
- R4: A jump-class word (`instr[23:22]`=2) with branch code 0x000 loads `pc` with `so_value`.
- R5: Branch codes 0x080 to 0x0AE (even only) test a flag. Let k=(code-0x080)/2. The flag is number k/4 in the order carry, zero, ov0, ov1, s0, s1, which are bits 0 to 5 of `flags_a`/`flags_b`. The accumulator is A when (k/2) is even and B when it is odd. The branch is taken when the flag equals k mod 2.
- R6: Codes 0x0B0, 0x0B1, 0x0B2 and 0x0B3 branch when `dp_low` is 0, is not 0, is 0xF, and is not 0xF respectively.
- R7: Codes 0x0B4/0x0B6 branch when `si_ack` is 0/1. Codes 0x0B8/0x0BA branch when `so_ack` is 0/1. Codes 0x0BC/0x0BE branch when `req_master` is 0/1.
- R8: A taken conditional branch loads `pc` with {bit 13 of `pc+1`, `instr[1:0]`, `instr[12:2]`}.
- R9: Code 0x100 loads the R8 target with bit 13 forced to 0. Code 0x101 loads it with bit 13 forced to 1. `sp` is unchanged.
- R10: Codes 0x140 and 0x141 behave as 0x100 and 0x101. They also write `pc+1` into the stack slot at `sp` and advance `sp` by 1 modulo 4.
- R11: A return-class word (`instr[23:22]`=1) decrements `sp` modulo 4 and loads `pc` from the slot at the decremented pointer.
- R12: Any other jump-class branch code, or a conditional branch whose condition is false, makes `pc` become `pc+1`, with `sp` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Execute the presented instruction this cycle |
| instr | input | 24 | Instruction word at the current `pc` |
| flags_a | input | 6 | Accumulator A flags: carry, zero, ov0, ov1, s0, s1 in bits 0 to 5 |
| flags_b | input | 6 | Accumulator B flags, same layout |
| dp_low | input | 4 | Low nibble of the data pointer |
| si_ack | input | 1 | Serial-input acknowledge status |
| so_ack | input | 1 | Serial-output acknowledge status |
| req_master | input | 1 | Request-for-master status |
| so_value | input | 14 | Serial-output register value used as a jump target |
| pc | output | 14 | Program counter (fetch address) |
| sp | output | 2 | Return-stack pointer |

## Verification
The assertions take for granted that every condition input and `instr` carry known values and stay stable across the edge on which `step` is high. They also assume `rst` is driven low or high with no unknown values. The bench changes all inputs only at falling edges and draws them from full random ranges, so flags, nibble and handshake values are always defined. Branch codes are drawn from the listed groups as well as from arbitrary 9-bit values, so that both taken and untaken outcomes occur and stack wrap happens naturally.

// File: rtl/seqr_pkg.sv
package seqr_pkg;

    localparam int INSTR_W = 24;
    localparam int PC_W    = 14;
    localparam int CODE_W  = 9;
    localparam int NA_W    = 11;
    localparam int BANK_W  = 2;

    typedef enum logic [1:0] {
        CLS_ALU  = 2'd0,
        CLS_RET  = 2'd1,
        CLS_JUMP = 2'd2,
        CLS_LOAD = 2'd3
    } instr_class_e;

    typedef struct packed {
        logic s1;
        logic s0;
        logic ov1;
        logic ov0;
        logic zero;
        logic carry;
    } acc_flags_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [NA_W-1:0]   next_addr;
        logic [BANK_W-1:0] bank;
    } jump_fields_t;

    typedef enum logic [2:0] {
        ACT_NEXT,
        ACT_TARGET,
        ACT_SERIAL,
        ACT_CALL,
        ACT_POP
    } pc_action_e;

    // select one flag by its kind number (carry first, s1 last)
    function automatic logic flag_pick(acc_flags_t f, logic [2:0] kind);
        logic v;
        case (kind)
            3'd0:    v = f.carry;
            3'd1:    v = f.zero;
            3'd2:    v = f.ov0;
            3'd3:    v = f.ov1;
            3'd4:    v = f.s0;
            3'd5:    v = f.s1;
            default: v = 1'b0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/branch_decode.sv
module branch_decode
    import seqr_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic [PC_W-1:0]    pc_inc,
    input  acc_flags_t         flags_a,
    input  acc_flags_t         flags_b,
    input  logic [3:0]         dp_low,
    input  logic               si_ack,
    input  logic               so_ack,
    input  logic               req_master,
    output pc_action_e         action,
    output logic [PC_W-1:0]    target
);

    localparam int FLAG_CODES = 24;

    instr_class_e      cls;
    jump_fields_t      jf;
    logic [PC_W-1:0]   base_tgt;

    logic              grp_flag, grp_dp, grp_io;
    logic [4:0]        fidx;
    acc_flags_t        fsel;
    logic              flag_hit, dp_hit, io_hit, io_bit;

    assign cls      = instr_class_e'(instr[INSTR_W-1 -: 2]);
    assign jf       = jump_fields_t'(instr[INSTR_W-3:0]);
    assign base_tgt = {pc_inc[PC_W-1], jf.bank, jf.next_addr};

    // accumulator flag tests
    assign fidx     = jf.code[5:1];
    assign grp_flag = (jf.code[8:6] == 3'b010) && !jf.code[0] &&
                      (fidx < 5'(FLAG_CODES));
    assign fsel     = fidx[1] ? flags_b : flags_a;
    assign flag_hit = flag_pick(fsel, fidx[4:2]) == fidx[0];

    // data pointer nibble tests
    assign grp_dp = (jf.code[8:2] == 7'b0101100);
    always_comb begin
        case (jf.code[1:0])
            2'd0:    dp_hit = (dp_low == 4'h0);
            2'd1:    dp_hit = (dp_low != 4'h0);
            2'd2:    dp_hit = (dp_low == 4'hF);
            default: dp_hit = (dp_low != 4'hF);
        endcase
    end

    // serial handshake and master request tests
    assign grp_io = (jf.code[8:4] == 5'b01011) && !jf.code[0] &&
                    (jf.code[3:2] != 2'b00);
    always_comb begin
        case (jf.code[3:2])
            2'b01:   io_bit = si_ack;
            2'b10:   io_bit = so_ack;
            default: io_bit = req_master;
        endcase
    end
    assign io_hit = (io_bit == jf.code[1]);

    always_comb begin
        action = ACT_NEXT;
        target = base_tgt;
        case (cls)
            CLS_RET: action = ACT_POP;
            CLS_JUMP: begin
                if (jf.code == 9'h000) begin
                    action = ACT_SERIAL;
                end else if (jf.code[8:1] == 8'h80 || jf.code[8:1] == 8'hA0) begin
                    // 0x100/0x101 jump, 0x140/0x141 call: bit 0 forces bit 13
                    target = {jf.code[0], base_tgt[PC_W-2:0]};
                    action = jf.code[6] ? ACT_CALL : ACT_TARGET;
                end else if (grp_flag) begin
                    action = flag_hit ? ACT_TARGET : ACT_NEXT;
                end else if (grp_dp) begin
                    action = dp_hit ? ACT_TARGET : ACT_NEXT;
                end else if (grp_io) begin
                    action = io_hit ? ACT_TARGET : ACT_NEXT;
                end
            end
            default: action = ACT_NEXT;
        endcase
    end

endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  logic                     pop,
    input  logic [W-1:0]             push_data,
    output logic [W-1:0]             top_data,
    output logic [$clog2(DEPTH)-1:0] ptr
);

    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] ptr_dec;

    assign ptr_dec  = ptr - PW'(1);
    assign top_data = slots[ptr_dec];

    always_ff @(posedge clk) begin
        if (rst)       ptr <= '0;
        else if (push) ptr <= ptr + PW'(1);
        else if (pop)  ptr <= ptr_dec;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)                          slot_q <= '0;
            else if (push && ptr == PW'(g))   slot_q <= push_data;
        end
        assign slots[g] = slot_q;
    end

endmodule

// File: rtl/branch_sequencer.sv
module branch_sequencer
    import seqr_pkg::*;
#(
    parameter int STACK_DEPTH = 4,
    localparam int SP_W = $clog2(STACK_DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [23:0]        instr,
    input  logic [5:0]         flags_a,
    input  logic [5:0]         flags_b,
    input  logic [3:0]         dp_low,
    input  logic               si_ack,
    input  logic               so_ack,
    input  logic               req_master,
    input  logic [13:0]        so_value,
    output logic [13:0]        pc,
    output logic [SP_W-1:0]    sp
);

    logic [PC_W-1:0] pc_inc, target, popped, pc_nxt;
    pc_action_e      action;
    logic            do_push, do_pop;

    assign pc_inc = pc + PC_W'(1);

    branch_decode u_dec (
        .instr      (instr),
        .pc_inc     (pc_inc),
        .flags_a    (acc_flags_t'(flags_a)),
        .flags_b    (acc_flags_t'(flags_b)),
        .dp_low     (dp_low),
        .si_ack     (si_ack),
        .so_ack     (so_ack),
        .req_master (req_master),
        .action     (action),
        .target     (target)
    );

    assign do_push = step && (action == ACT_CALL);
    assign do_pop  = step && (action == ACT_POP);

    ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (do_push),
        .pop       (do_pop),
        .push_data (pc_inc),
        .top_data  (popped),
        .ptr       (sp)
    );

    always_comb begin
        case (action)
            ACT_TARGET, ACT_CALL: pc_nxt = target;
            ACT_SERIAL:           pc_nxt = so_value;
            ACT_POP:              pc_nxt = popped;
            default:              pc_nxt = pc_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (step) pc <= pc_nxt;
    end

endmodule

// File: rtl/seqr_checker.sv
module seqr_checker #(
    parameter int SP_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            step,
    input logic [23:0]     instr,
    input logic [5:0]      flags_a,
    input logic [13:0]     so_value,
    input logic [13:0]     pc,
    input logic [SP_W-1:0] sp
);

    logic is_jump;
    assign is_jump = step && instr[23:22] == 2'd2;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc == 14'd0 && sp == '0));                                       // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(pc) && $stable(sp)));                                  // R2
    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (step && (instr[23:22] == 2'd0 || instr[23:22] == 2'd3))
        |=> (pc == 14'($past(pc) + 14'd1) && $stable(sp)));                       // R3
    AST_SERIAL_JUMP: assert property (@(posedge clk) disable iff (rst)
        (is_jump && instr[21:13] == 9'h000) |=> pc == $past(so_value));           // R4
    AST_FAILED_CARRY: assert property (@(posedge clk) disable iff (rst)
        (is_jump && instr[21:13] == 9'h080 && flags_a[0])
        |=> pc == 14'($past(pc) + 14'd1));                                        // R12
    AST_HIGH_JUMP: assert property (@(posedge clk) disable iff (rst)
        (is_jump && instr[21:13] == 9'h101)
        |=> (pc[13] && pc[12:0] == $past({instr[1:0], instr[12:2]})));            // R9
    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (rst)
        (is_jump && instr[21:14] == 8'hA0) |=> sp == SP_W'($past(sp) + 1'b1));   // R10
    AST_RET_POP: assert property (@(posedge clk) disable iff (rst)
        (step && instr[23:22] == 2'd1) |=> sp == SP_W'($past(sp) - 1'b1));       // R11

endmodule

bind branch_sequencer seqr_checker #(.SP_W(SP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .instr    (instr),
    .flags_a  (flags_a),
    .so_value (so_value),
    .pc       (pc),
    .sp       (sp)
);

// File: tb/branch_sequencer_test.sv
`timescale 1ns/1ps
module branch_sequencer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [23:0] instr = '0;
    logic [5:0]  flags_a = '0, flags_b = '0;
    logic [3:0]  dp_low = '0;
    logic        si_ack = 1'b0, so_ack = 1'b0, req_master = 1'b0;
    logic [13:0] so_value = '0;
    logic [13:0] pc;
    logic [1:0]  sp;

    always #2.5 clk = ~clk;

    branch_sequencer uut (
        .clk(clk), .rst(rst), .step(step), .instr(instr),
        .flags_a(flags_a), .flags_b(flags_b), .dp_low(dp_low),
        .si_ack(si_ack), .so_ack(so_ack), .req_master(req_master),
        .so_value(so_value), .pc(pc), .sp(sp)
    );

    int    checks = 0, fails = 0;
    int    m_pc = 0, m_sp = 0;
    int    m_stk[4] = '{0, 0, 0, 0};
    string tag = "R1";
    bit    done = 0;

    task automatic compare();
        checks++;
        if (pc !== 14'(m_pc) || sp !== 2'(m_sp)) begin
            fails++;
            $display("FAIL %s pc=%h sp=%0d expected pc=%h sp=%0d",
                     tag, pc, sp, 14'(m_pc), 2'(m_sp));
        end
    endtask

    // reference: one executed instruction, written from the requirement text
    task automatic model_step();
        int nxt, code, tgt, k, j, v;
        bit taken;
        if (!step) begin tag = "R2"; return; end
        nxt = (m_pc + 1) % 16384;
        case (int'(instr[23:22]))
            1: begin
                m_sp = (m_sp + 3) % 4;
                m_pc = m_stk[m_sp];
                tag = "R11";
            end
            2: begin
                code = int'(instr[21:13]);
                tgt  = (nxt / 8192) * 8192 + int'(instr[1:0]) * 2048 + int'(instr[12:2]);
                tgt  = tgt % 8192 + (nxt >= 8192 ? 8192 : 0);
                if (code == 0) begin
                    m_pc = int'(so_value); tag = "R4";
                end else if (code == 'h100 || code == 'h101 || code == 'h140 || code == 'h141) begin
                    tgt = tgt % 8192 + ((code % 2 == 1) ? 8192 : 0);
                    if (code >= 'h140) begin
                        m_stk[m_sp] = nxt;
                        m_sp = (m_sp + 1) % 4;
                        tag = "R10";
                    end else tag = "R9";
                    m_pc = tgt;
                end else if (code >= 'h080 && code <= 'h0AE && code % 2 == 0) begin
                    k = (code - 'h080) / 2;
                    v = ((k / 2) % 2 == 0) ? int'(flags_a[k/4]) : int'(flags_b[k/4]);
                    taken = (v == k % 2);
                    m_pc = taken ? tgt : nxt;
                    tag = taken ? "R5 R8" : "R5 R12";
                end else if (code >= 'h0B0 && code <= 'h0B3) begin
                    case (code)
                        'h0B0: taken = (dp_low == 0);
                        'h0B1: taken = (dp_low != 0);
                        'h0B2: taken = (dp_low == 15);
                        default: taken = (dp_low != 15);
                    endcase
                    m_pc = taken ? tgt : nxt;
                    tag = "R6";
                end else if (code >= 'h0B4 && code <= 'h0BE && code % 2 == 0) begin
                    j = (code - 'h0B4) / 2;
                    v = (j < 2) ? int'(si_ack) : (j < 4) ? int'(so_ack) : int'(req_master);
                    m_pc = (v == j % 2) ? tgt : nxt;
                    tag = "R7";
                end else begin
                    m_pc = nxt; tag = "R12";
                end
            end
            default: begin m_pc = nxt; tag = "R3"; end
        endcase
    endtask

    function automatic logic [8:0] pick_code();
        int r = $urandom_range(0, 9);
        case (r)
            0: return 9'h000;
            1: return 9'h100 + 9'($urandom_range(0, 1));
            2, 3: return 9'h140 + 9'($urandom_range(0, 1));
            4, 5: return 9'(9'h080 + 2 * $urandom_range(0, 23));
            6: return 9'(9'h0B0 + $urandom_range(0, 3));
            7: return 9'(9'h0B4 + 2 * $urandom_range(0, 5));
            default: return 9'($urandom);
        endcase
    endfunction

    task automatic drive_random();
        int r = $urandom_range(0, 99);
        step       = (r >= 8);
        instr      = 24'($urandom);
        if (r < 45)      instr[23:22] = 2'd2;
        else if (r < 58) instr[23:22] = 2'd1;
        if (instr[23:22] == 2'd2) instr[21:13] = pick_code();
        flags_a    = 6'($urandom);
        flags_b    = 6'($urandom);
        dp_low     = ($urandom_range(0, 2) == 0) ? 4'h0 :
                     ($urandom_range(0, 1) == 0) ? 4'hF : 4'($urandom);
        si_ack     = 1'($urandom);
        so_ack     = 1'($urandom);
        req_master = 1'($urandom);
        so_value   = 14'($urandom);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        tag = "R1";
        compare();
        rst = 1'b0;
        // R2: idle cycle first
        @(negedge clk);
        compare();
        for (int i = 0; i < 4000; i++) begin
            drive_random();
            model_step();
            @(negedge clk);
            compare();
        end
        // mid-run reset returns to origin (R1)
        step = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        m_pc = 0; m_sp = 0; m_stk = '{0, 0, 0, 0}; tag = "R1";
        compare();
        rst = 1'b0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired pc=%h expected progress", pc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule